// File: doc/BRIEF.md
# GPIO Mismatch Interrupt Unit

This block watches eight general-purpose inputs, grouped as two ports of four pins. Each pin has a stored reference bit. Whenever a pin's synchronized level differs from its reference, the pin's interrupt state bit is set. A single interrupt output is raised while any pin's interrupt state bit is set.

Software reads one 32-bit word that holds the interrupt state and the reference bits. It acknowledges an interrupt by writing a command bit that forces the reference high or low. The pin then matches again, so the interrupt drops. The new reference value also selects which edge is reported next.

When a pin's interrupt state is set, its reference bit gives the direction of the edge. A reference of 0 means the pin rose. A reference of 1 means the pin fell.

Register access is a plain one-cycle write strobe with a data word. The read word is always valid. Both are control and status pins, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_mismatch_irq`

## Requirements
- R1: After reset, every reference bit is 0, every interrupt state bit is 0, `rd_data` reads 0 and `irq_o` is low.
- R2: Interrupt state bit i (`rd_data[i]`) equals the pin level sampled two clock edges earlier, XOR reference bit i. A pin change therefore shows up on the second rising edge after it is applied, and not on the first.
- R3: A cycle with `wr_en` high and `wr_data[16+i]` = 1 (set command) makes reference bit i (`rd_data[8+i]`) 1 from the next edge onward.
- R4: A cycle with `wr_en` high and `wr_data[24+i]` = 1 (clear command) makes reference bit i 0 from the next edge onward.
- R5: When the set and clear commands for the same pin are both 1 in one write, the clear command wins and the reference bit becomes 0.
- R6: Command bits written as 0 leave their reference bits unchanged. Data written to bits 15..0 is ignored. Any `wr_data` value has no effect while `wr_en` is low.
- R7: An acknowledge that makes the reference equal the pin level clears that pin's interrupt state in the cycle after the write. If the pin still mismatches after the write, the state bit stays set.
- R8: While a state bit is set, its reference bit tells the edge direction: 0 after a low-to-high change and 1 after a high-to-low change.
- R9: `irq_o` is the OR of the eight interrupt state bits.
- R10: In every 8-bit field, pin p of port q sits at bit offset 4*q + p. Port 0 uses the lower nibble and port 1 the upper nibble.
- R11: Bits 31..16 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Raw pin levels, index 4*port+pin |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write word: set commands in 23..16, clear commands in 31..24 |
| rd_data | output | 32 | Read word: state in 7..0, reference in 15..8, zero above |
| irq_o | output | 1 | Combined interrupt |

## Verification
A single pin is first taken low to high and back, which separates a rising cause from a falling cause by the reference bit read back. A pin in the upper nibble confirms that the port 1 mapping is not mixed up with port 0. Acknowledges are written both with a matching level and with a still-mismatched level, which distinguishes a state that is cleared from one that re-asserts. Conflicting set/clear writes, zero or read-only data, and data driven with the strobe low show the clear priority and the ignore rules. A multi-pin pattern across both ports checks the combined interrupt and a bulk acknowledge.

// File: rtl/gmi_pkg.sv
package gmi_pkg;
  // Field index inside the register word; each field is NPIN bits wide.
  localparam int FLD_STATE = 0;
  localparam int FLD_REF   = 1;
  localparam int FLD_SET   = 2;
  localparam int FLD_CLR   = 3;
  localparam int NUM_FLDS  = 4;
endpackage

// File: rtl/gmi_sync.sv
module gmi_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gmi_cmd_decode.sv
module gmi_cmd_decode
  import gmi_pkg::*;
#(
  parameter int NPIN  = 8,
  localparam int REG_W = NUM_FLDS * NPIN
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NPIN-1:0]  set_o,
  output logic [NPIN-1:0]  clr_o
);
  always_comb begin
    set_o = wr_en ? wr_data[FLD_SET*NPIN +: NPIN] : '0;
    clr_o = wr_en ? wr_data[FLD_CLR*NPIN +: NPIN] : '0;
  end
endmodule

// File: rtl/gmi_ref_reg.sv
module gmi_ref_reg #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] ref_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ref_o[i] <= 1'b0;
      else if (clr_i[i]) ref_o[i] <= 1'b0;   // clear has priority
      else if (set_i[i]) ref_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_mismatch_irq.sv
module gpio_mismatch_irq
  import gmi_pkg::*;
#(
  parameter int NPORT         = 2,
  parameter int PINS_PER_PORT = 4,
  parameter int SYNC_STAGES   = 2,
  localparam int NPIN  = NPORT * PINS_PER_PORT,
  localparam int REG_W = NUM_FLDS * NPIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pins_i,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_o
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] set_cmd;
  logic [NPIN-1:0] clr_cmd;
  logic [NPIN-1:0] ref_q;
  logic [NPIN-1:0] state;

  gmi_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pin_sync)
  );

  gmi_cmd_decode #(.NPIN(NPIN)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .set_o(set_cmd), .clr_o(clr_cmd)
  );

  gmi_ref_reg #(.NPIN(NPIN)) u_ref (
    .clk(clk), .rst_n(rst_n), .set_i(set_cmd), .clr_i(clr_cmd), .ref_o(ref_q)
  );

  // Mismatch is evaluated combinationally so it re-asserts right after
  // an acknowledge that leaves the pin different from its reference.
  assign state = pin_sync ^ ref_q;

  always_comb begin
    rd_data = '0;
    rd_data[FLD_STATE*NPIN +: NPIN] = state;
    rd_data[FLD_REF*NPIN   +: NPIN] = ref_q;
  end

  assign irq_o = |state;
endmodule

// File: rtl/gmi_checker.sv
module gmi_checker #(
  parameter int NPIN  = 8,
  localparam int REG_W = 4 * NPIN
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIN-1:0]  pins_i,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  wire [NPIN-1:0] st  = rd_data[NPIN-1:0];
  wire [NPIN-1:0] rf  = rd_data[2*NPIN-1:NPIN];
  wire [NPIN-1:0] setv = wr_data[2*NPIN +: NPIN];
  wire [NPIN-1:0] clrv = wr_data[3*NPIN +: NPIN];

  p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (st != '0));

  p_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (st == (rf ^ $past(pins_i, 2))));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rf & $past(setv & ~clrv)) == $past(setv & ~clrv)));

  p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rf & $past(clrv)) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (setv == '0 && clrv == '0)) |=> $stable(rf));
endmodule

bind gpio_mismatch_irq gmi_checker i_gmi_checker (
  .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/test_gpio_mismatch_irq.sv
module test_gpio_mismatch_irq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_i = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mismatch_irq i_gpio_mismatch_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_rise_then_ack;
    pins_i = 8'h01;
    @(negedge clk);
    chk("R2 one edge", rd_data, 32'h0);
    @(negedge clk);
    chk("R2 R8 rising cause ref0", rd_data, 32'h0000_0001);
    chk("R9 irq up", {31'b0, irq_o}, 32'h1);
    write_word(32'h0001_0000);
    chk("R3 R7 set ack", rd_data, 32'h0000_0100);
    chk("R9 irq down", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fall_then_ack;
    pins_i = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R8 falling cause ref1", rd_data, 32'h0000_0101);
    write_word(32'h0100_0000);
    chk("R4 clear ack", rd_data, 32'h0);
  endtask

  task automatic t_port1_pin;
    pins_i = 8'h40;
    @(negedge clk); @(negedge clk);
    chk("R10 port1 pin2 state", rd_data, 32'h0000_0040);
    write_word(32'h0040_0000);
    chk("R10 port1 pin2 ref", rd_data, 32'h0000_4000);
  endtask

  task automatic t_reassert;
    write_word(32'h4000_0000);
    chk("R7 reassert mismatch", rd_data, 32'h0000_0040);
    write_word(32'h0040_0000);
    chk("R7 restore", rd_data, 32'h0000_4000);
  endtask

  task automatic t_both_cmds;
    write_word(32'h0002_0000);
    chk("R3 set pin1", rd_data, 32'h0000_4202);
    write_word(32'h0202_0000);
    chk("R5 clear wins", rd_data, 32'h0000_4000);
  endtask

  task automatic t_ignore;
    write_word(32'h0000_FFFF);
    chk("R6 low field write", rd_data, 32'h0000_4000);
    wr_data = 32'hFFFF_FFFF; wr_en = 1'b0;
    @(negedge clk);
    wr_data = '0;
    chk("R6 no strobe", rd_data, 32'h0000_4000);
    chk("R11 upper zero", {16'b0, rd_data[31:16]}, 32'h0);
  endtask

  task automatic t_multi;
    pins_i = 8'hC3;
    @(negedge clk); @(negedge clk);
    chk("R9 R10 multi state", rd_data, 32'h0000_4083);
    chk("R9 multi irq", {31'b0, irq_o}, 32'h1);
    write_word(32'h0083_0000);
    chk("R3 bulk ack", rd_data, 32'h0000_C300);
    chk("R9 irq clear", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_then_ack();
    t_fall_then_ack();
    t_port1_pin();
    t_reassert();
    t_both_cmds();
    t_ignore();
    t_multi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule